// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the horizontal and vertical timing of a low-resolution, VGA-style raster from two cascaded counters. A pixel counter advances on every cycle in which the pixel-clock enable is high. At the start of each horizontal sync pulse, the horizontal stage emits a single-cycle gate. That gate is the only advance enable of the line counter, so the line counter steps exactly once per scan line.

The vertical stage builds its own single-cycle gate in the same way, at the start of its sync pulse. That gate is exported as a frame strobe. Downstream pixel logic can use it to restart its fetch for the next frame. Both sync outputs are active low and registered. The horizontal and vertical blanking flags are also registered, and an OR of the two gives the combined blanking flag. The pixel and line positions are available at the ports.

The pins are plain control and status signals. There is no data stream and no back-pressure: pixel logic follows the timing and cannot stall it. All timing values are parameters.

Defaults:

| Axis | Total | Active | Sync position | Sync width |
|------|-------|--------|---------------|------------|
| Horizontal | 381 | 256 | 292 | 46 |
| Vertical | 528 | 480 | 494 | 2 |

Top module: `vga_raster_timing`

## Requirements
- R1: `pix_x` advances by one on each clock edge where `pix_en` is high. It goes from `H_TOTAL-1` (default 380) back to 0, so a line lasts `H_TOTAL` enabled cycles.
- R2: `hsync_n` is low exactly while `pix_x` is in the range `H_SYNC_BEG` to `H_SYNC_BEG+H_SYNC_LEN-1` (default 292 to 337). With `pix_en` held high, each low pulse is 46 clock cycles.
- R3: `hblank` is high exactly while `pix_x` is at least `H_ACTIVE` (default 256).
- R4: `line_y` advances by one on the clock edge that follows the falling edge of `hsync_n`. It goes from `V_TOTAL-1` (default 527) back to 0.
- R5: `vsync_n` is low exactly while `line_y` is in the range `V_SYNC_BEG` to `V_SYNC_BEG+V_SYNC_LEN-1` (default lines 494 and 495).
- R6: `vblank` is high exactly while `line_y` is at least `V_ACTIVE` (default 480). `blank` equals `hblank` OR `vblank`.
- R7: `frame_end` is high for exactly one clock cycle, in the cycle where `vsync_n` falls. This happens once per `V_TOTAL` lines.
- R8: While `rst` is high at a clock edge, the block clears its state. After that edge `pix_x` and `line_y` are 0, `hsync_n` and `vsync_n` are 1, and `hblank`, `vblank`, `blank` and `frame_end` are 0.
- R9: A cycle with `pix_en` low leaves `pix_x`, `hsync_n` and `hblank` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable; each high cycle is one pixel time |
| hsync_n | output | 1 | Horizontal sync, active low, registered |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| blank | output | 1 | Combined blanking (horizontal OR vertical) |
| pix_x | output | clog2(H_TOTAL) (9) | Pixel position within the line |
| line_y | output | clog2(V_TOTAL) (10) | Line position within the frame |
| frame_end | output | 1 | One-cycle frame strobe at the start of vertical sync |

## Verification
The bench uses two configurations:
- **Default timing.** This instance checks the exact horizontal numbers: the 380 wrap, the 292/338 sync edges and the 256 blanking boundary.
- **Small timing.** This instance completes several full frames in a short run, which exposes the line wrap, the vertical sync window and the frame strobe.

Three input patterns are applied:
- **Continuous enable.** This pattern checks the nominal periods and the measured width of each sync pulse.
- **Pseudo-random enable gaps.** This pattern separates enable-gated state from the line gate. The gate must still last one clock and advance the line counter exactly once.
- **Reset in the middle of a frame.** This pattern shows that every output returns to its cleared value, whatever the raster position.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Width of a counter that must hold the values 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/raster_axis.sv
// One timing axis: a wrapping position counter with registered blank,
// active-low sync and a single-cycle gate at the sync leading edge.
module raster_axis #(
  parameter int TOTAL    = 381,
  parameter int ACTIVE   = 256,
  parameter int SYNC_BEG = 292,
  parameter int SYNC_LEN = 46,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          blank,
  output logic          sync_n,
  output logic          gate
);

  localparam logic [CW-1:0] LAST    = CW'(TOTAL - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(SYNC_BEG - 1);
  localparam logic [CW-1:0] RISE_AT = CW'(SYNC_BEG + SYNC_LEN - 1);
  localparam logic [CW-1:0] ACT_END = CW'(ACTIVE);

  logic [CW-1:0] nxt;

  assign nxt = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      blank  <= 1'b0;
      sync_n <= 1'b1;
      gate   <= 1'b0;
    end else begin
      // The gate rises together with the falling sync edge and lasts one clock
      gate <= adv && (cnt == FALL_AT);
      if (adv) begin
        cnt   <= nxt;
        blank <= (nxt >= ACT_END);
        if (cnt == FALL_AT)
          sync_n <= 1'b0;
        else if (cnt == RISE_AT)
          sync_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vga_raster_timing.sv
module vga_raster_timing
  import raster_pkg::*;
#(
  parameter int H_TOTAL    = 381,
  parameter int H_ACTIVE   = 256,
  parameter int H_SYNC_BEG = 292,
  parameter int H_SYNC_LEN = 46,
  parameter int V_TOTAL    = 528,
  parameter int V_ACTIVE   = 480,
  parameter int V_SYNC_BEG = 494,
  parameter int V_SYNC_LEN = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pix_en,
  output logic                       hsync_n,
  output logic                       vsync_n,
  output logic                       hblank,
  output logic                       vblank,
  output logic                       blank,
  output logic [cnt_w(H_TOTAL)-1:0]  pix_x,
  output logic [cnt_w(V_TOTAL)-1:0]  line_y,
  output logic                       frame_end
);

  localparam int XW = cnt_w(H_TOTAL);
  localparam int YW = cnt_w(V_TOTAL);

  logic line_gate;

  // Pixel axis, stepped by the pixel-clock enable
  raster_axis #(
    .TOTAL(H_TOTAL), .ACTIVE(H_ACTIVE),
    .SYNC_BEG(H_SYNC_BEG), .SYNC_LEN(H_SYNC_LEN), .CW(XW)
  ) u_line_axis (
    .clk(clk), .rst(rst), .adv(pix_en),
    .cnt(pix_x), .blank(hblank), .sync_n(hsync_n), .gate(line_gate)
  );

  // Line axis, stepped once per line by the horizontal gate; its gate is the frame strobe
  raster_axis #(
    .TOTAL(V_TOTAL), .ACTIVE(V_ACTIVE),
    .SYNC_BEG(V_SYNC_BEG), .SYNC_LEN(V_SYNC_LEN), .CW(YW)
  ) u_frame_axis (
    .clk(clk), .rst(rst), .adv(line_gate),
    .cnt(line_y), .blank(vblank), .sync_n(vsync_n), .gate(frame_end)
  );

  assign blank = hblank | vblank;

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
#(
  parameter int H_TOTAL    = 381,
  parameter int H_SYNC_BEG = 292,
  parameter int H_SYNC_LEN = 46,
  parameter int V_TOTAL    = 528,
  parameter int V_SYNC_BEG = 494
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      pix_en,
  input logic                      hsync_n,
  input logic                      vsync_n,
  input logic                      hblank,
  input logic [cnt_w(H_TOTAL)-1:0] pix_x,
  input logic [cnt_w(V_TOTAL)-1:0] line_y,
  input logic                      frame_end
);

  localparam int XW = cnt_w(H_TOTAL);
  localparam int YW = cnt_w(V_TOTAL);
  localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
  localparam logic [XW-1:0] X_SB   = XW'(H_SYNC_BEG);
  localparam logic [XW-1:0] X_SE   = XW'(H_SYNC_BEG + H_SYNC_LEN);
  localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);
  localparam logic [YW-1:0] Y_SB   = YW'(V_SYNC_BEG);

  assert_x_range_R1: assert property (@(posedge clk) disable iff (rst)
    pix_x <= X_LAST);

  assert_x_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (pix_en && pix_x == X_LAST) |=> (pix_x == '0));

  assert_hsync_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> (pix_x == X_SB));

  assert_hsync_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> (pix_x == X_SE));

  assert_y_range_R4: assert property (@(posedge clk) disable iff (rst)
    line_y <= Y_LAST);

  assert_vsync_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> (line_y == Y_SB));

  assert_frame_single_R7: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  assert_frame_at_vsync_R7: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> $fell(vsync_n));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(pix_x) && $stable(hsync_n) && $stable(hblank)));

endmodule

bind vga_raster_timing raster_timing_chk #(
  .H_TOTAL(H_TOTAL), .H_SYNC_BEG(H_SYNC_BEG), .H_SYNC_LEN(H_SYNC_LEN),
  .V_TOTAL(V_TOTAL), .V_SYNC_BEG(V_SYNC_BEG)
) u_raster_timing_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .hsync_n(hsync_n),
  .vsync_n(vsync_n), .hblank(hblank), .pix_x(pix_x), .line_y(line_y),
  .frame_end(frame_end)
);

// File: tb/test_vga_raster_timing.sv
`timescale 1ns/1ps

// Arithmetic expectation: position from the number of enabled cycles,
// lines from the number of line gates taken.
module raster_expect #(
  parameter int HT = 381, parameter int HA = 256, parameter int HSB = 292, parameter int HSL = 46,
  parameter int VT = 528, parameter int VA = 480, parameter int VSB = 494, parameter int VSL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output int   ex_x,
  output int   ex_y,
  output bit   ex_hs_n,
  output bit   ex_vs_n,
  output bit   ex_hb,
  output bit   ex_vb,
  output bit   ex_eof
);
  int ticks = 0;
  int lines = 0;
  bit pend  = 0;
  bit eof_r = 0;

  always @(posedge clk) begin
    bit ng, ne;
    if (rst) begin
      ticks = 0; lines = 0; pend = 0; eof_r = 0;
    end else begin
      ng = en && ((ticks % HT) == HSB - 1);
      ne = pend && ((lines % VT) == VSB - 1);
      if (pend) lines = lines + 1;
      if (en) ticks = ticks + 1;
      pend  = ng;
      eof_r = ne;
    end
  end

  assign ex_x    = ticks % HT;
  assign ex_y    = lines % VT;
  assign ex_hs_n = !(ex_x >= HSB && ex_x < HSB + HSL);
  assign ex_vs_n = !(ex_y >= VSB && ex_y < VSB + VSL);
  assign ex_hb   = (ex_x >= HA);
  assign ex_vb   = (ex_y >= VA);
  assign ex_eof  = eof_r;
endmodule

module test_vga_raster_timing;
  logic clk = 0;
  logic rst = 1;
  logic en  = 0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit phase_a = 0;
  bit phase_b = 0;
  int eof_seen = 0;
  int run_s = 0;
  int run_d = 0;

  // small configuration
  logic s_hs, s_vs, s_hb, s_vb, s_bl, s_eof;
  logic [4:0] s_x;
  logic [3:0] s_y;
  vga_raster_timing #(
    .H_TOTAL(20), .H_ACTIVE(12), .H_SYNC_BEG(14), .H_SYNC_LEN(3),
    .V_TOTAL(10), .V_ACTIVE(6), .V_SYNC_BEG(7), .V_SYNC_LEN(2)
  ) i_vga_raster_timing (
    .clk(clk), .rst(rst), .pix_en(en), .hsync_n(s_hs), .vsync_n(s_vs),
    .hblank(s_hb), .vblank(s_vb), .blank(s_bl), .pix_x(s_x), .line_y(s_y),
    .frame_end(s_eof)
  );
  int sx, sy; bit shs, svs, shb, svb, seof;
  raster_expect #(.HT(20), .HA(12), .HSB(14), .HSL(3), .VT(10), .VA(6), .VSB(7), .VSL(2))
    u_exp_s (.clk(clk), .rst(rst), .en(en), .ex_x(sx), .ex_y(sy), .ex_hs_n(shs),
             .ex_vs_n(svs), .ex_hb(shb), .ex_vb(svb), .ex_eof(seof));

  // default configuration
  logic d_hs, d_vs, d_hb, d_vb, d_bl, d_eof;
  logic [8:0] d_x;
  logic [9:0] d_y;
  vga_raster_timing i_vga_raster_timing_dflt (
    .clk(clk), .rst(rst), .pix_en(en), .hsync_n(d_hs), .vsync_n(d_vs),
    .hblank(d_hb), .vblank(d_vb), .blank(d_bl), .pix_x(d_x), .line_y(d_y),
    .frame_end(d_eof)
  );
  int dx, dy; bit dhs, dvs, dhb, dvb, deof;
  raster_expect u_exp_d (.clk(clk), .rst(rst), .en(en), .ex_x(dx), .ex_y(dy), .ex_hs_n(dhs),
                         .ex_vs_n(dvs), .ex_hb(dhb), .ex_vb(dvb), .ex_eof(deof));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string tag, input int ax, input int ay, input bit ahs, input bit avs,
                         input bit ahb, input bit avb, input bit abl, input bit aeof,
                         input int ex, input int ey, input bit ehs, input bit evs,
                         input bit ehb, input bit evb, input bit eeof);
    string th, tv;
    th = rst ? "R8" : (phase_b ? "R9" : "R1");
    tv = rst ? "R8" : "R4";
    chk(ax == ex, th, {tag, " pix_x"}, ax, ex);
    chk(ahs == ehs, rst ? "R8" : (phase_b ? "R9" : "R2"), {tag, " hsync_n"}, int'(ahs), int'(ehs));
    chk(ahb == ehb, rst ? "R8" : (phase_b ? "R9" : "R3"), {tag, " hblank"}, int'(ahb), int'(ehb));
    chk(ay == ey, tv, {tag, " line_y"}, ay, ey);
    chk(avs == evs, rst ? "R8" : "R5", {tag, " vsync_n"}, int'(avs), int'(evs));
    chk(avb == evb, rst ? "R8" : "R6", {tag, " vblank"}, int'(avb), int'(evb));
    chk(abl == (ehb | evb), rst ? "R8" : "R6", {tag, " blank"}, int'(abl), int'(ehb | evb));
    chk(aeof == eeof, rst ? "R8" : "R7", {tag, " frame_end"}, int'(aeof), int'(eeof));
  endtask

  bit started = 0;
  always @(negedge clk) begin
    if (started) begin
      cmp_all("small", int'(s_x), int'(s_y), s_hs, s_vs, s_hb, s_vb, s_bl, s_eof,
              sx, sy, shs, svs, shb, svb, seof);
      cmp_all("dflt", int'(d_x), int'(d_y), d_hs, d_vs, d_hb, d_vb, d_bl, d_eof,
              dx, dy, dhs, dvs, dhb, dvb, deof);
      if (phase_a) begin
        if (s_eof) eof_seen++;
        // measured sync widths with continuous enable (R2)
        if (!s_hs) run_s++;
        else if (run_s > 0) begin chk(run_s == 3, "R2", "small hsync width", run_s, 3); run_s = 0; end
        if (!d_hs) run_d++;
        else if (run_d > 0) begin chk(run_d == 46, "R2", "dflt hsync width", run_d, 46); run_d = 0; end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // reset state (R8)
    step(); started = 1;
    step(); step();
    rst = 0; en = 1; phase_a = 1;
    // continuous enable: nominal periods (R1..R7)
    repeat (900) step();
    phase_a = 0;
    chk(eof_seen == 4, "R7", "frame_end count in 900 cycles", eof_seen, 4);
    // gapped enable: holding and single gate (R9, R4, R7)
    phase_b = 1;
    for (int i = 0; i < 2400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      en = lfsr[0];
      step();
    end
    phase_b = 0;
    // mid-frame reset (R8)
    en = 1; rst = 1;
    repeat (3) step();
    rst = 0;
    repeat (300) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule